// File: doc/BRIEF.md
# Dual-Port Video Memory Arbiter

This block decides, every cycle, which of six clients may use a dual-port video memory. Port A is shared by three clients. Two of them are read/write masters: a processor and a debug probe. The third is a colour-table fetcher that only reads. Port B is shared by three read-only display fetchers: a first tile fetcher, a second tile fetcher and a sprite fetcher. Each client raises a request strobe together with an address, and the read/write clients also drive a write flag. Each client gets its grant bit back in the same cycle.

Port A resolves contention by fixed priority. Port B rotates fairly among its readers. The block also guards against cross-port hazards. When port A is granted a write, any port B reader aimed at that same address is removed from the port B contest before the rotating choice is made. A non-conflicting reader can therefore still win that cycle. A denied client is not queued. It keeps requesting, and it wins once the hazard has cleared.

Top module: `vmem_arbiter`

## Requirements
- R1: Port A grants at most one client per cycle. The processor beats the debug probe, and the debug probe beats the colour-table fetcher, whatever the write flags or addresses are.
- R2: Port B grants at most one client per cycle, and only to a client that is requesting and eligible. The rotation order is tile-A, then tile-B, then sprite, then back to tile-A.
- R3: The port B search starts at the client just after the most recent port B winner. The rotation state changes only in a cycle that issues a port B grant. After reset, tile-A is the first choice.
- R4: A port B client that is the only eligible requester is granted, whatever the rotation state.
- R5: If the port A client that holds the grant is writing, every port B reader at the same address is denied in that cycle. This applies to both a processor write and a debug-probe write. A write by a port A client that did not get the grant has no effect on port B.
- R6: A granted port A read at the same address as a port B read is not a conflict. A granted port A write to a different address is not a conflict either. In both cases both ports are granted.
- R7: Conflicting port B readers are dropped before the rotation choice. Another port B reader with no conflict is granted in that same cycle.
- R8: A port B reader that was denied by a conflict is granted in a later cycle, by the normal rotation rules, once the conflicting write is gone. A cycle in which every port B requester was masked does not move the rotation.
- R9: Grants are combinational from the current cycle's inputs. A port with no eligible requester drives all of its grants low, including while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rotation state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request strobe (port A) |
| cpu_wr | input | 1 | Processor write flag, 1 = write |
| cpu_addr | input | ADDR_W | Processor address |
| dbg_req | input | 1 | Debug probe request strobe (port A) |
| dbg_wr | input | 1 | Debug probe write flag, 1 = write |
| dbg_addr | input | ADDR_W | Debug probe address |
| pal_req | input | 1 | Colour-table fetch request (port A, read only) |
| pal_addr | input | ADDR_W | Colour-table fetch address |
| tla_req | input | 1 | Tile-A fetch request (port B) |
| tla_addr | input | ADDR_W | Tile-A fetch address |
| tlb_req | input | 1 | Tile-B fetch request (port B) |
| tlb_addr | input | ADDR_W | Tile-B fetch address |
| spr_req | input | 1 | Sprite fetch request (port B) |
| spr_addr | input | ADDR_W | Sprite fetch address |
| cpu_gnt | output | 1 | Processor granted this cycle |
| dbg_gnt | output | 1 | Debug probe granted this cycle |
| pal_gnt | output | 1 | Colour-table fetcher granted this cycle |
| tla_gnt | output | 1 | Tile-A fetcher granted this cycle |
| tlb_gnt | output | 1 | Tile-B fetcher granted this cycle |
| spr_gnt | output | 1 | Sprite fetcher granted this cycle |

## Verification
The assertions assume that every request, write flag and address holds a known value and stays stable around the sampling edge. The grants are combinational, so any glitch on an input would reach the outputs directly. The bench drives every input on the falling edge and sets all of them to zero at time zero, so each clocked property sees settled values. A full sweep covers all request combinations, all write-flag pairs and a set of address patterns that place port B readers both on and off the write address. The stimulus also crosses the rotation state, because the grants feed back into it cycle after cycle.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;

   // Port A client slots, in descending priority
   localparam int unsigned A_CPU = 0;
   localparam int unsigned A_DBG = 1;
   localparam int unsigned A_PAL = 2;
   localparam int unsigned A_CNT = 3;

   // Port B client slots, in rotation order
   localparam int unsigned B_TLA = 0;
   localparam int unsigned B_TLB = 1;
   localparam int unsigned B_SPR = 2;
   localparam int unsigned B_CNT = 3;

   // Width of an index into a set of n clients
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/vma_fixed_pick.sv
module vma_fixed_pick #(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] req,
   output logic [NUM-1:0] gnt
);

   if (NUM < 1) begin : g_bad_num
      $error("vma_fixed_pick: NUM must be at least 1");
   end

   // Lowest index wins
   always_comb begin
      logic taken;
      gnt   = '0;
      taken = 1'b0;
      for (int i = 0; i < NUM; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

   AST_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("port A grant not one-hot"); // R1
   AST_A_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> gnt[0]) else $error("top priority client lost"); // R1
   AST_A_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("grant without request"); // R1
   AST_A_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0)) else $error("port A idle while requested"); // R9

endmodule

// File: rtl/vma_conflict_mask.sv
module vma_conflict_mask #(
   parameter int unsigned NA     = 3,
   parameter int unsigned NB     = 3,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [NA-1:0]     a_gnt,
   input  logic [NA-1:0]     a_wr,
   input  logic [ADDR_W-1:0] a_addr [NA],
   input  logic [NB-1:0]     b_req,
   input  logic [ADDR_W-1:0] b_addr [NB],
   output logic [NB-1:0]     b_elig
);

   if (ADDR_W < 1) begin : g_bad_aw
      $error("vma_conflict_mask: ADDR_W must be at least 1");
   end

   logic              wr_on;
   logic [ADDR_W-1:0] wr_addr;

   // Port A grant is one-hot, so an OR-select gives the write address
   always_comb begin
      wr_on   = 1'b0;
      wr_addr = '0;
      for (int i = 0; i < NA; i++) begin
         if (a_gnt[i] && a_wr[i]) begin
            wr_on   = 1'b1;
            wr_addr = wr_addr | a_addr[i];
         end
      end
   end

   for (genvar j = 0; j < NB; j++) begin : g_cmp
      logic hit;
      assign hit       = wr_on && (b_addr[j] == wr_addr);
      assign b_elig[j] = b_req[j] && !hit;
   end

endmodule

// File: rtl/vma_rr_pick.sv
module vma_rr_pick
   import vmem_arb_pkg::*;
#(
   parameter int unsigned NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] req,
   output logic [NUM-1:0] gnt
);

   localparam int unsigned IDX_W = idx_width(NUM);
   localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM - 1);

   if (NUM < 2) begin : g_bad_num
      $error("vma_rr_pick: NUM must be at least 2");
   end

   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] win_idx;

   // Search begins one past the previous winner
   always_comb begin
      logic taken;
      int   pos;
      gnt     = '0;
      win_idx = last_q;
      taken   = 1'b0;
      for (int k = 1; k <= NUM; k++) begin
         pos = (int'(last_q) + k) % NUM;
         if (req[pos] && !taken) begin
            gnt[pos] = 1'b1;
            win_idx  = IDX_W'(pos);
            taken    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= LAST_RST;
      else if (|gnt)    last_q <= win_idx;
   end

   AST_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("port B grant not one-hot"); // R2
   AST_B_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("port B grant without eligible request"); // R2
   AST_B_LONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) == 1) |-> (gnt == req)) else $error("lone requester lost"); // R4
   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0) |=> $stable(last_q)) else $error("rotation moved without grant"); // R3
   AST_B_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0)) else $error("port B idle while requested"); // R9

endmodule

// File: rtl/vmem_arbiter.sv
module vmem_arbiter
   import vmem_arb_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              dbg_req,
   input  logic              dbg_wr,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic              pal_req,
   input  logic [ADDR_W-1:0] pal_addr,
   input  logic              tla_req,
   input  logic [ADDR_W-1:0] tla_addr,
   input  logic              tlb_req,
   input  logic [ADDR_W-1:0] tlb_addr,
   input  logic              spr_req,
   input  logic [ADDR_W-1:0] spr_addr,
   output logic              cpu_gnt,
   output logic              dbg_gnt,
   output logic              pal_gnt,
   output logic              tla_gnt,
   output logic              tlb_gnt,
   output logic              spr_gnt
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("vmem_arbiter: ADDR_W out of range");
   end

   logic [A_CNT-1:0]  a_req, a_wr, a_gnt;
   logic [ADDR_W-1:0] a_addr [A_CNT];
   logic [B_CNT-1:0]  b_req, b_elig, b_gnt;
   logic [ADDR_W-1:0] b_addr [B_CNT];

   // Gather client signals into slot-indexed vectors
   always_comb begin
      a_req[A_CPU]  = cpu_req;
      a_req[A_DBG]  = dbg_req;
      a_req[A_PAL]  = pal_req;
      a_wr[A_CPU]   = cpu_wr;
      a_wr[A_DBG]   = dbg_wr;
      a_wr[A_PAL]   = 1'b0;
      a_addr[A_CPU] = cpu_addr;
      a_addr[A_DBG] = dbg_addr;
      a_addr[A_PAL] = pal_addr;
      b_req[B_TLA]  = tla_req;
      b_req[B_TLB]  = tlb_req;
      b_req[B_SPR]  = spr_req;
      b_addr[B_TLA] = tla_addr;
      b_addr[B_TLB] = tlb_addr;
      b_addr[B_SPR] = spr_addr;
   end

   vma_fixed_pick #(.NUM(A_CNT)) u_port_a (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (a_req),
      .gnt   (a_gnt)
   );

   vma_conflict_mask #(.NA(A_CNT), .NB(B_CNT), .ADDR_W(ADDR_W)) u_mask (
      .a_gnt  (a_gnt),
      .a_wr   (a_wr),
      .a_addr (a_addr),
      .b_req  (b_req),
      .b_addr (b_addr),
      .b_elig (b_elig)
   );

   vma_rr_pick #(.NUM(B_CNT)) u_port_b (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (b_elig),
      .gnt   (b_gnt)
   );

   assign cpu_gnt = a_gnt[A_CPU];
   assign dbg_gnt = a_gnt[A_DBG];
   assign pal_gnt = a_gnt[A_PAL];
   assign tla_gnt = b_gnt[B_TLA];
   assign tlb_gnt = b_gnt[B_TLB];
   assign spr_gnt = b_gnt[B_SPR];

   // Cross-port hazard checks at the ports
   AST_CPU_WR_TLA: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_wr && tla_gnt) |-> (tla_addr != cpu_addr)) else $error("tile-A read under processor write"); // R5
   AST_CPU_WR_TLB: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_wr && tlb_gnt) |-> (tlb_addr != cpu_addr)) else $error("tile-B read under processor write"); // R5
   AST_CPU_WR_SPR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_wr && spr_gnt) |-> (spr_addr != cpu_addr)) else $error("sprite read under processor write"); // R5
   AST_DBG_WR_TLA: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_gnt && dbg_wr && tla_gnt) |-> (tla_addr != dbg_addr)) else $error("tile-A read under probe write"); // R5
   AST_DBG_WR_SPR: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_gnt && dbg_wr && spr_gnt) |-> (spr_addr != dbg_addr)) else $error("sprite read under probe write"); // R5
   AST_READ_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_wr && tla_req && !tlb_req && !spr_req) |-> tla_gnt) else $error("read/read blocked"); // R6

endmodule

// File: tb/vmem_arbiter_tb.sv
module vmem_arbiter_tb;

   localparam int AW    = 4;
   localparam time CLK_P = 20ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [5:0]    rq = '0;
   logic [1:0]    wr = '0;
   logic [AW-1:0] ad [6];
   logic cpu_gnt, dbg_gnt, pal_gnt, tla_gnt, tlb_gnt, spr_gnt;

   initial for (int i = 0; i < 6; i++) ad[i] = '0;

   vmem_arbiter #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(rq[0]), .cpu_wr(wr[0]), .cpu_addr(ad[0]),
      .dbg_req(rq[1]), .dbg_wr(wr[1]), .dbg_addr(ad[1]),
      .pal_req(rq[2]), .pal_addr(ad[2]),
      .tla_req(rq[3]), .tla_addr(ad[3]),
      .tlb_req(rq[4]), .tlb_addr(ad[4]),
      .spr_req(rq[5]), .spr_addr(ad[5]),
      .cpu_gnt(cpu_gnt), .dbg_gnt(dbg_gnt), .pal_gnt(pal_gnt),
      .tla_gnt(tla_gnt), .tlb_gnt(tlb_gnt), .spr_gnt(spr_gnt)
   );

   int n_chk = 0;
   int n_fail = 0;
   int last = 2;   // model: most recent port B winner, tile-A first after reset
   bit done = 0;

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %03b expected %03b", tag, got, exp);
      end
   endtask

   // Drive one cycle, compare both ports to the model, advance the model
   task automatic step(input logic [5:0] r, input logic [1:0] w,
                       input int a0, input int a1, input int a2,
                       input int a3, input int a4, input int a5,
                       input string tag);
      logic [2:0] ea, eb, el;
      logic       won;
      logic [AW-1:0] wa;
      @(negedge clk);
      rq = r; wr = w;
      ad[0] = AW'(a0); ad[1] = AW'(a1); ad[2] = AW'(a2);
      ad[3] = AW'(a3); ad[4] = AW'(a4); ad[5] = AW'(a5);
      #2ns;
      ea = r[0] ? 3'b001 : r[1] ? 3'b010 : r[2] ? 3'b100 : 3'b000;
      won = (ea[0] && w[0]) || (ea[1] && w[1]);
      wa  = ea[0] ? AW'(a0) : AW'(a1);
      for (int j = 0; j < 3; j++)
         el[j] = r[3+j] && !(won && ad[3+j] == wa);
      eb = '0;
      for (int k = 1; k <= 3; k++) begin
         int p;
         p = (last + k) % 3;
         if (eb == '0 && el[p]) eb[p] = 1'b1;
      end
      check({tag, " portA"}, {pal_gnt, dbg_gnt, cpu_gnt}, ea);
      check({tag, " portB"}, {spr_gnt, tlb_gnt, tla_gnt}, eb);
      if (eb != '0) last = eb[0] ? 0 : eb[1] ? 1 : 2;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: outputs low while held in reset with no requests
      #5ns;
      check("R9 reset A", {pal_gnt, dbg_gnt, cpu_gnt}, 3'b000);
      check("R9 reset B", {spr_gnt, tlb_gnt, tla_gnt}, 3'b000);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      step(6'b000000, 2'b00, 0,0,0,0,0,0, "R9 idle");
      // R3: first choice after reset is tile-A (explicit)
      @(negedge clk);
      rq = 6'b111000; wr = '0;
      for (int i = 0; i < 6; i++) ad[i] = AW'(i);
      #2ns;
      check("R3 reset first choice", {spr_gnt, tlb_gnt, tla_gnt}, 3'b001);
      last = 0;
      // R1: single clients and priority
      step(6'b000001, 2'b00, 1,0,0,0,0,0, "R1 cpu read");
      step(6'b000001, 2'b01, 1,0,0,0,0,0, "R1 cpu write");
      step(6'b000010, 2'b10, 0,1,0,0,0,0, "R1 dbg write");
      step(6'b000100, 2'b00, 0,0,1,0,0,0, "R1 pal read");
      step(6'b000111, 2'b00, 1,2,3,0,0,0, "R1 all three");
      step(6'b000110, 2'b00, 0,2,3,0,0,0, "R1 dbg over pal");
      // R4: lone B requesters
      step(6'b001000, 2'b00, 0,0,0,1,0,0, "R4 tile-A alone");
      step(6'b010000, 2'b00, 0,0,0,0,1,0, "R4 tile-B alone");
      step(6'b100000, 2'b00, 0,0,0,0,0,1, "R4 sprite alone");
      // R2/R3: rotation with all three, then partial sets
      for (int i = 0; i < 4; i++) step(6'b111000, 2'b00, 0,0,0,1,2,3, "R2 rotate");
      step(6'b101000, 2'b00, 0,0,0,1,0,3, "R3 tileA+sprite");
      step(6'b110000, 2'b00, 0,0,0,0,2,3, "R3 tileB+sprite");
      step(6'b110000, 2'b00, 0,0,0,0,2,3, "R3 tileB+sprite again");
      // R6: no-conflict cases
      step(6'b001001, 2'b00, 0,0,0,0,0,0, "R6 read/read same addr");
      step(6'b001001, 2'b01, 1,0,0,0,0,0, "R6 write other addr");
      // R5: conflicts
      step(6'b001001, 2'b01, 0,0,0,0,0,0, "R5 cpu write vs tile-A");
      step(6'b010001, 2'b01, 0,0,0,0,0,0, "R5 cpu write vs tile-B");
      step(6'b100001, 2'b01, 0,0,0,0,0,0, "R5 cpu write vs sprite");
      step(6'b001010, 2'b10, 0,0,0,0,0,0, "R5 dbg write vs tile-A");
      step(6'b001011, 2'b10, 5,0,0,0,0,0, "R5 ungranted dbg write ignored");
      // R7/R8: masking before rotation, then recovery
      step(6'b100000, 2'b00, 0,0,0,0,0,1, "R8 set rotation");
      step(6'b111001, 2'b01, 0,0,0,0,0,0, "R8 all masked keeps rotation");
      step(6'b011001, 2'b01, 0,0,0,0,1,0, "R7 other reader wins");
      step(6'b001000, 2'b00, 0,0,0,0,0,0, "R8 recovered");
      // Sweep: all requests, write pairs and address patterns
      for (int r = 0; r < 64; r++)
         for (int w = 0; w < 4; w++)
            for (int p = 0; p < 8; p++)
               step(6'(r), 2'(w), p & 1, (p >> 1) & 1, 0, (p >> 2) & 1,
                    (p & 1) ^ ((p >> 2) & 1), (p >> 1) & 1, "R1 R2 R5 R7 sweep");
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule